// File: doc/BRIEF.md
# Mux-Based ALU with Carry-Chain Equality

A 16-bit arithmetic and logic unit built on one ripple-carry adder. In front of each adder input, every bit goes through a small function multiplexer. The multiplexer takes the operand bit pair as its address and picks one of four control lines. This lets each side of the adder produce any two-input logic function of the A and B bits. An operation decoder turns a 2-bit op code into those control lines and the carry-in. Four operations are supported: add, subtract, OR and equality compare.

There is no zero-detect tree. The equality compare drives the bitwise XNOR of the operands into one side of the adder and zero into the other, with carry-in forced to 1. A bit passes a carry upward only when its carry-in is 1 and its two operand bits match. The final carry-out is therefore 1 exactly when all the bits match.

Result and carry-out are combinational. A carry flag register captures the carry-out on a clock edge when its write enable is high, so a later step of a controller can branch or set a register on it.

Top module: `alu_carry_eq`

## Requirements
- R1: With op_i = 0 (add), result_o and carry_o in the same cycle give the 17-bit sum a_i + b_i, with carry_o as the top bit.
- R2: With op_i = 1 (subtract), {carry_o, result_o} equals a_i + ~b_i + 1. carry_o is 1 exactly when a_i >= b_i, taken as unsigned values.
- R3: With op_i = 2 (or), result_o equals a_i | b_i and carry_o is 0.
- R4: With op_i = 3 (equality), carry_o is 1 if and only if a_i equals b_i in every bit position.
- R5: With op_i = 3, result_o equals (~(a_i ^ b_i)) + 1 modulo 2^16. It is therefore 0 when the operands are equal.
- R6: On a rising clk_i edge with flag_we_i = 1, carry_flag_o takes the value carry_o had just before the edge.
- R7: On a rising clk_i edge with flag_we_i = 0, carry_flag_o keeps its value, whatever carry_o is.
- R8: While rst_ni = 0, carry_flag_o is 0, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| op_i | input | 2 | Operation: 0 add, 1 subtract, 2 or, 3 equality |
| flag_we_i | input | 1 | Write enable of the carry flag |
| result_o | output | 16 | Combinational result |
| carry_o | output | 1 | Combinational carry-out of the adder |
| carry_flag_o | output | 1 | Registered carry flag |

## Verification
On every cycle the assertions check the add, subtract, or and equality results against the operands. They also check that the flag loads the carry-out when enabled and holds when not. The bench's scenarios show what a property cannot cover. These are specific boundary values: a wrap of the full width, a difference in the top bit only, a difference in the bottom bit only, and equal operands at zero and at all ones. The bench also shows the asynchronous clear of the flag and that the flag keeps its value across cycles where the carry changes while writes are disabled.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_OR  = 2'd2,
    OP_EQ  = 2'd3
  } alu_op_e;

  // Function table, bit index = {a, b}
  typedef logic [3:0] fn_lut_t;

  localparam fn_lut_t LUT_ZERO = 4'b0000;
  localparam fn_lut_t LUT_A    = 4'b1100;
  localparam fn_lut_t LUT_B    = 4'b1010;
  localparam fn_lut_t LUT_NB   = 4'b0101;
  localparam fn_lut_t LUT_OR   = 4'b1110;
  localparam fn_lut_t LUT_XNOR = 4'b1001;

  typedef struct packed {
    fn_lut_t lut_x;
    fn_lut_t lut_y;
    logic    cin;
  } alu_ctrl_t;
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
(
  input  logic [1:0] op_i,
  output alu_ctrl_t  ctrl_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  always_comb begin
    ctrl_o = '{lut_x: LUT_A, lut_y: LUT_ZERO, cin: 1'b0};
    unique case (op)
      OP_ADD: ctrl_o = '{lut_x: LUT_A,    lut_y: LUT_B,    cin: 1'b0};
      OP_SUB: ctrl_o = '{lut_x: LUT_A,    lut_y: LUT_NB,   cin: 1'b1};
      OP_OR:  ctrl_o = '{lut_x: LUT_OR,   lut_y: LUT_ZERO, cin: 1'b0};
      OP_EQ:  ctrl_o = '{lut_x: LUT_XNOR, lut_y: LUT_ZERO, cin: 1'b1};
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_fn_mux.sv
module alu_fn_mux
  import alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  fn_lut_t      lut_i,
  output logic [W-1:0] f_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] sel;
    assign sel    = {a_i[i], b_i[i]};
    assign f_o[i] = lut_i[sel];
  end
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p        = x_i[i] ^ y_i[i];
    assign sum_o[i] = p ^ c[i];
    assign c[i+1]   = (x_i[i] & y_i[i]) | (p & c[i]);
  end

  assign cout_o = c[W];
endmodule

// File: rtl/alu_carry_flag.sv
module alu_carry_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/alu_carry_eq.sv
module alu_carry_eq
  import alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  input  logic         flag_we_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         carry_flag_o
);
  alu_ctrl_t   ctrl;
  logic [W-1:0] x_side, y_side;

  alu_op_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  alu_fn_mux #(.W(W)) u_mux_x (
    .a_i   (a_i),
    .b_i   (b_i),
    .lut_i (ctrl.lut_x),
    .f_o   (x_side)
  );

  alu_fn_mux #(.W(W)) u_mux_y (
    .a_i   (a_i),
    .b_i   (b_i),
    .lut_i (ctrl.lut_y),
    .f_o   (y_side)
  );

  alu_ripple_adder #(.W(W)) u_add (
    .x_i    (x_side),
    .y_i    (y_side),
    .cin_i  (ctrl.cin),
    .sum_o  (result_o),
    .cout_o (carry_o)
  );

  alu_carry_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (flag_we_i),
    .d_i    (carry_o),
    .q_o    (carry_flag_o)
  );
endmodule

// File: rtl/alu_carry_eq_checker.sv
module alu_carry_eq_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [1:0]   op_i,
  input logic         flag_we_i,
  input logic [W-1:0] result_o,
  input logic         carry_o,
  input logic         carry_flag_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_ADD_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd0) |-> ({carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i}))); // R1
  AST_SUB_BORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd1) |-> (result_o == W'(a_i - b_i) && carry_o == (a_i >= b_i))); // R2
  AST_OR_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd2) |-> (result_o == (a_i | b_i) && !carry_o)); // R3
  AST_EQ_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd3) |-> (carry_o == (a_i == b_i))); // R4
  AST_EQ_ZERO_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd3 && a_i == b_i) |-> (result_o == '0)); // R5
  AST_FLAG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && flag_we_i) |=> (carry_flag_o == $past(carry_o))); // R6
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !flag_we_i) |=> $stable(carry_flag_o)); // R7
endmodule

bind alu_carry_eq alu_carry_eq_checker #(.W(W)) u_chk (.*);

// File: tb/alu_carry_eq_test.sv
`timescale 1ns/1ps
module alu_carry_eq_test;
  localparam int W = 16;
  localparam int NV = 13;

  // {op, a, b, expected result, expected carry}
  typedef struct packed {
    logic [1:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] res;
    logic         cy;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'h1234, 16'h0001, 16'h1235, 1'b0},
    '{2'd0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1},
    '{2'd0, 16'h8000, 16'h8000, 16'h0000, 1'b1},
    '{2'd1, 16'h0005, 16'h0003, 16'h0002, 1'b1},
    '{2'd1, 16'h0003, 16'h0005, 16'hFFFE, 1'b0},
    '{2'd1, 16'h1234, 16'h1234, 16'h0000, 1'b1},
    '{2'd2, 16'h00F0, 16'h0F00, 16'h0FF0, 1'b0},
    '{2'd2, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b0},
    '{2'd3, 16'hABCD, 16'hABCD, 16'h0000, 1'b1},
    '{2'd3, 16'hABCD, 16'hABCC, 16'hFFFF, 1'b0},
    '{2'd3, 16'h0000, 16'h8000, 16'h8000, 1'b0},
    '{2'd3, 16'h0000, 16'h0000, 16'h0000, 1'b1},
    '{2'd3, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [1:0]   op = '0;
  logic         we = 1'b0;
  logic [W-1:0] res;
  logic         cy, flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  alu_carry_eq #(.W(W)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .a_i          (a),
    .b_i          (b),
    .op_i         (op),
    .flag_we_i    (we),
    .result_o     (res),
    .carry_o      (cy),
    .carry_flag_o (flag)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] o, input logic carry);
    case (o)
      2'd0: return carry ? "R1 add carry" : "R1 add";
      2'd1: return carry ? "R2 sub carry" : "R2 sub";
      2'd2: return carry ? "R3 or carry" : "R3 or";
      default: return carry ? "R4 eq carry" : "R5 eq result";
    endcase
  endfunction

  initial begin
    #5;
    chk("R8 flag in reset", W'(flag), W'(0));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R9-style same-cycle combinational table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op = VECS[i].op; a = VECS[i].a; b = VECS[i].b;
      #1;
      chk(req_of(VECS[i].op, 1'b0), res, VECS[i].res);
      chk(req_of(VECS[i].op, 1'b1), W'(cy), W'(VECS[i].cy));
    end

    // Eq single-bit difference in lsb: carry must be 0
    @(negedge clk);
    op = 2'd3; a = 16'h0001; b = 16'h0000; #1;
    chk("R4 eq lsb diff", W'(cy), W'(0));
    chk("R5 eq lsb diff", res, 16'hFFFF);

    // R6: load carry=1
    @(negedge clk);
    op = 2'd3; a = 16'h5A5A; b = 16'h5A5A; we = 1'b1;
    @(negedge clk);
    chk("R6 flag load one", W'(flag), W'(1));
    // R7: hold while carry is 0 and writes disabled
    we = 1'b0; a = 16'h5A5B;
    @(negedge clk);
    @(negedge clk);
    chk("R7 flag hold", W'(flag), W'(1));
    #1;
    chk("R7 carry changed", W'(cy), W'(0));
    // R6: load carry=0
    we = 1'b1;
    @(negedge clk);
    chk("R6 flag load zero", W'(flag), W'(0));
    // R6 with subtract carry
    op = 2'd1; a = 16'h0010; b = 16'h0001;
    @(negedge clk);
    chk("R6 flag load sub", W'(flag), W'(1));
    we = 1'b0;
    // R8: async clear between edges
    #3;
    rst_n = 1'b0;
    #2;
    chk("R8 async clear", W'(flag), W'(0));
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule